// File: doc/BRIEF.md
# Packed Event Interrupt Controller

The block gathers per-channel FIFO event pulses from ten channels, each of which can report six event kinds. Every event kind has three views: an enable bit, a sticky pending bit, and a masked status bit. The masked status bit is the pending bit ANDed with the enable bit. The bits are packed into 32-bit words. Each word holds four channels, and each channel owns one 8-bit slot in that word. There is one word per group of four channels, so channels 0-3, 4-7 and 8-9 fall in words 0, 1 and 2 of every bank.

A second mask sits above this, with one bit per channel. It selects which channels may drive the single level interrupt output towards the processor. Software reads the masked status to find the cause, then writes ones to the clear bank to acknowledge it.

The register port is a plain synchronous write with a combinational read. The address is five bits wide. Bits [4:2] select the bank: 0 enable, 1 clear, 2 raw, 3 masked, 4 processor mask. Bits [1:0] select the word within the bank.

Top module: `evtirq_top`

## Requirements
- R1: After reset every readable word is zero and `irqOut` is low.
- R2: A pulse on `evtPulse[ch*6+type]` sets the raw bit at word `ch/4`, bit `(ch%4)*8+type`. The type codes are: 0 capture almost-empty, 1 capture almost-full, 2 playback almost-empty, 3 playback almost-full, 4 capture overflow, 5 playback overflow. The bit is readable after the next clock edge and stays set until it is cleared.
- R3: Writing a word to the clear bank (addresses 4-6) clears every raw bit whose matching data bit is 1. Raw bits whose data bit is 0 keep their value.
- R4: When an event pulse and a clear of the same raw bit fall in the same cycle, the bit ends up set.
- R5: A masked status word (addresses 12-14) reads as the raw word ANDed with the enable word of the same index.
- R6: Enable words (addresses 0-2) are written and read back. Slot bits 6 and 7, and the slots of channels 10 and 11, always read 0.
- R7: The processor mask word (address 16) holds channel bits 0-9. Bits 10-31 read 0.
- R8: `irqOut` is high exactly when some channel has a masked status bit set and its processor mask bit set. It follows the register state in the same cycle.
- R9: Writes to the raw and masked banks, and to unmapped addresses, change no state. Clear-bank and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 60 | Event pulses, bit ch*6+type |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address {bank[2:0], word[1:0]} |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
An event pulse and a software clear can strike the same raw bit in one clock cycle. These collisions are provoked in two ways:
- A directed case pulses a bit while writing its clear.
- The random phase sends sparse event pulses together with clear-bank writes that carry random data.

A bench model applies the clear first and the set second. Each result is judged by reading the raw and masked words back through the register port, and by comparing `irqOut` with the model after every cycle.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
  localparam int SLOT_W      = 8;
  localparam int CH_PER_WORD = 4;
  localparam int DATA_W      = SLOT_W * CH_PER_WORD;
  localparam int WORD_SEL_W  = 2;
  localparam int MAX_WORDS   = 1 << WORD_SEL_W;
  localparam int BANK_SEL_W  = 3;
  localparam int ADDR_W      = BANK_SEL_W + WORD_SEL_W;

  // event kind positions inside a slot; software decodes them by bit
  localparam int EV_CAP_AE = 0;
  localparam int EV_CAP_AF = 1;
  localparam int EV_PB_AE  = 2;
  localparam int EV_PB_AF  = 3;
  localparam int EV_CAP_OV = 4;
  localparam int EV_PB_OV  = 5;

  typedef enum logic [BANK_SEL_W-1:0] {
    BANK_ENABLE = 3'd0,
    BANK_CLEAR  = 3'd1,
    BANK_RAW    = 3'd2,
    BANK_MASKED = 3'd3,
    BANK_CPU    = 3'd4
  } bank_e;

  typedef struct packed {
    logic [MAX_WORDS-1:0]  wrEnable;
    logic [MAX_WORDS-1:0]  wrClear;
    logic                  wrCpuMask;
    bank_e                 rdBank;
    logic [WORD_SEL_W-1:0] rdWord;
  } strobe_t;
endpackage

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  bank_e                 bankSel;
  logic [WORD_SEL_W-1:0] wordSel;

  assign bankSel = bank_e'(regAddr[ADDR_W-1 -: BANK_SEL_W]);
  assign wordSel = regAddr[WORD_SEL_W-1:0];

  always_comb begin
    strb        = '0;
    strb.rdBank = bankSel;
    strb.rdWord = wordSel;
    for (int w = 0; w < MAX_WORDS; w++) begin
      if (WORD_SEL_W'(w) == wordSel) begin
        strb.wrEnable[w] = regWrEn && (bankSel == BANK_ENABLE);
        strb.wrClear[w]  = regWrEn && (bankSel == BANK_CLEAR);
      end
    end
    strb.wrCpuMask = regWrEn && (bankSel == BANK_CPU) && (wordSel == '0);
  end
endmodule

// File: rtl/evtirq_datapath.sv
module evtirq_datapath
  import evtirq_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int NUM_TYPES = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic [NUM_CH*NUM_TYPES-1:0] evtPulse,
  output logic [DATA_W-1:0]           regRdData,
  output logic                        irqOut
);
  localparam int FLAT_W = NUM_CH * NUM_TYPES;

  logic [FLAT_W-1:0] rawFlat;
  logic [FLAT_W-1:0] enFlat;
  logic [FLAT_W-1:0] enNext;
  logic [FLAT_W-1:0] clrFlat;
  logic [FLAT_W-1:0] mskFlat;
  logic [NUM_CH-1:0] cpuMask;
  logic [NUM_CH-1:0] chHit;

  logic [DATA_W-1:0] enWord  [MAX_WORDS];
  logic [DATA_W-1:0] rawWord [MAX_WORDS];
  logic [DATA_W-1:0] mskWord [MAX_WORDS];

  // per-channel slot decode of the write data
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int WIDX = ch / CH_PER_WORD;
    localparam int BASE = (ch % CH_PER_WORD) * SLOT_W;
    assign clrFlat[ch*NUM_TYPES +: NUM_TYPES] =
      strb.wrClear[WIDX] ? regWrData[BASE +: NUM_TYPES] : '0;
    assign enNext[ch*NUM_TYPES +: NUM_TYPES] =
      strb.wrEnable[WIDX] ? regWrData[BASE +: NUM_TYPES]
                          : enFlat[ch*NUM_TYPES +: NUM_TYPES];
    assign chHit[ch] = cpuMask[ch] && (|mskFlat[ch*NUM_TYPES +: NUM_TYPES]);
  end

  assign mskFlat = rawFlat & enFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawFlat <= '0;
      enFlat  <= '0;
      cpuMask <= '0;
    end else begin
      // clear first, then set: a coincident pulse survives
      rawFlat <= (rawFlat & ~clrFlat) | evtPulse;
      enFlat  <= enNext;
      if (strb.wrCpuMask) cpuMask <= regWrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    for (int w = 0; w < MAX_WORDS; w++) begin
      enWord[w]  = '0;
      rawWord[w] = '0;
      mskWord[w] = '0;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      enWord[c/CH_PER_WORD][(c%CH_PER_WORD)*SLOT_W +: NUM_TYPES]  =
        enFlat[c*NUM_TYPES +: NUM_TYPES];
      rawWord[c/CH_PER_WORD][(c%CH_PER_WORD)*SLOT_W +: NUM_TYPES] =
        rawFlat[c*NUM_TYPES +: NUM_TYPES];
      mskWord[c/CH_PER_WORD][(c%CH_PER_WORD)*SLOT_W +: NUM_TYPES] =
        mskFlat[c*NUM_TYPES +: NUM_TYPES];
    end
  end

  always_comb begin
    regRdData = '0;
    case (strb.rdBank)
      BANK_ENABLE: regRdData = enWord[strb.rdWord];
      BANK_RAW:    regRdData = rawWord[strb.rdWord];
      BANK_MASKED: regRdData = mskWord[strb.rdWord];
      BANK_CPU:    if (strb.rdWord == '0) regRdData = DATA_W'(cpuMask);
      default:     regRdData = '0;
    endcase
  end

  assign irqOut = |chHit;

  // R2
  set_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawFlat & $past(evtPulse)) == $past(evtPulse)));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rawFlat) & ~$past(clrFlat) & ~rawFlat) == '0));

  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawFlat & $past(clrFlat & ~evtPulse)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawFlat & $past(evtPulse & clrFlat)) == $past(evtPulse & clrFlat)));

  // R8
  irq_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (cpuMask != '0));

  // R9
  raw_only_by_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawFlat & ~$past(rawFlat) & ~$past(evtPulse)) == '0));
endmodule

// File: rtl/evtirq_top.sv
module evtirq_top
  import evtirq_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int NUM_TYPES = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH*NUM_TYPES-1:0] evtPulse,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  output logic                        irqOut
);
  strobe_t strb;

  evtirq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  evtirq_datapath #(
    .NUM_CH    (NUM_CH),
    .NUM_TYPES (NUM_TYPES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .evtPulse  (evtPulse),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/evtirq_top_tb.sv
`timescale 1ns/1ps
module evtirq_top_tb;
  localparam int NCH = 10;
  localparam int NT  = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NCH*NT-1:0] evtPulse = '0;
  logic          regWrEn = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [NT-1:0]  mEn  [NCH];
  logic [NT-1:0]  mRaw [NCH];
  logic [NCH-1:0] mCpu;

  always #2.5 clk = ~clk;

  evtirq_top u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [4:0] a);
    logic [31:0] r;
    int bank;
    int word;
    r = '0;
    bank = int'(a[4:2]);
    word = int'(a[1:0]);
    for (int c = 0; c < NCH; c++) begin
      if (c / 4 == word) begin
        if (bank == 0) r[(c%4)*8 +: NT] = mEn[c];
        if (bank == 2) r[(c%4)*8 +: NT] = mRaw[c];
        if (bank == 3) r[(c%4)*8 +: NT] = mRaw[c] & mEn[c];
      end
    end
    if (bank == 4 && word == 0) r = 32'(mCpu);
    return r;
  endfunction

  function automatic logic expIrq();
    logic v;
    v = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (mCpu[c] && |(mRaw[c] & mEn[c])) v = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mEn[c]  = '0;
      mRaw[c] = '0;
    end
    mCpu = '0;
  endtask

  // one clock with the given stimulus; model updated after the edge
  task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d,
                     input logic [NCH*NT-1:0] ev);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; evtPulse = ev;
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      if (we && a[4:2] == 3'd1 && int'(a[1:0]) == c / 4)
        mRaw[c] = mRaw[c] & ~d[(c%4)*8 +: NT];
      mRaw[c] = mRaw[c] | ev[c*NT +: NT];
      if (we && a[4:2] == 3'd0 && int'(a[1:0]) == c / 4)
        mEn[c] = d[(c%4)*8 +: NT];
    end
    if (we && a == 5'd16) mCpu = d[NCH-1:0];
  endtask

  task automatic rd(input string req, input logic [4:0] a);
    @(negedge clk);
    regWrEn = 1'b0; evtPulse = '0; regAddr = a;
    #1;
    chk(req, regRdData, expRead(a));
  endtask

  task automatic chkIrq(input string req);
    @(negedge clk);
    #1;
    chk(req, 32'(irqOut), 32'(expIrq()));
  endtask

  function automatic logic [NCH*NT-1:0] oneEvt(input int c, input int t);
    logic [NCH*NT-1:0] v;
    v = '0;
    v[c*NT + t] = 1'b1;
    return v;
  endfunction

  initial begin
    #500000;
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [NCH*NT-1:0] ev;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 17; a++) rd("R1 reset", 5'(a));
    chkIrq("R1 irq low");

    // R2 channel 5 playback almost-full -> word 1 bit 11
    cyc(1'b0, 5'd0, 32'd0, oneEvt(5, 3));
    rd("R2 raw set", 5'd9);
    chk("R2 bit position", regRdData, 32'h0000_0800);
    cyc(1'b0, 5'd0, 32'd0, '0);
    cyc(1'b0, 5'd0, 32'd0, '0);
    rd("R2 sticky", 5'd9);
    // channel 9 playback overflow -> word 2 bit 13
    cyc(1'b0, 5'd0, 32'd0, oneEvt(9, 5));
    rd("R2 ch9", 5'd10);
    chk("R2 ch9 bit", regRdData, 32'h0000_2000);

    // R3 clear with zero bits keeps, one bit clears
    cyc(1'b1, 5'd5, 32'hFFFF_F7FF, '0);
    rd("R3 zero bit keeps", 5'd9);
    cyc(1'b1, 5'd5, 32'h0000_0800, '0);
    rd("R3 cleared", 5'd9);
    chk("R3 cleared value", regRdData, 32'h0);

    // R4 pulse and clear of the same bit in one cycle
    cyc(1'b1, 5'd6, 32'h0000_2000, oneEvt(9, 5));
    rd("R4 set wins", 5'd10);
    chk("R4 set wins value", regRdData, 32'h0000_2000);

    // R6 enable readback with padding bits
    cyc(1'b1, 5'd2, 32'hFFFF_FFFF, '0);
    rd("R6 enable pad", 5'd2);
    chk("R6 enable pad value", regRdData, 32'h0000_3F3F);
    // R5 masked
    rd("R5 masked", 5'd14);
    chk("R5 masked value", regRdData, 32'h0000_2000);

    // R7 processor mask width
    cyc(1'b1, 5'd16, 32'hFFFF_FFFF, '0);
    rd("R7 cpu mask", 5'd16);
    chk("R7 cpu mask value", regRdData, 32'h0000_03FF);
    // R8 irq on
    chkIrq("R8 irq on");
    chk("R8 irq on value", 32'(irqOut), 32'd1);
    cyc(1'b1, 5'd16, 32'h0000_01FF, '0);
    chkIrq("R8 irq masked by cpu");
    chk("R8 irq off value", 32'(irqOut), 32'd0);

    // R9 writes to raw/masked/unmapped ignored; clear reads zero
    cyc(1'b1, 5'd10, 32'h0, '0);
    cyc(1'b1, 5'd14, 32'h0, '0);
    cyc(1'b1, 5'd20, 32'hFFFF_FFFF, '0);
    cyc(1'b1, 5'd3, 32'hFFFF_FFFF, '0);
    rd("R9 raw untouched", 5'd10);
    rd("R9 clear reads zero", 5'd6);
    rd("R9 unmapped reads zero", 5'd20);
    rd("R9 cpu untouched", 5'd16);

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic we;
      logic [4:0] a;
      logic [31:0] d;
      ev = '0;
      for (int b = 0; b < NCH*NT; b++)
        ev[b] = (($urandom() % 24) == 0);
      we = ($urandom() % 3) != 0;
      a  = 5'($urandom() % 20);
      d  = $urandom();
      if (($urandom() % 4) == 0) a = 5'(4 + ($urandom() % 3));
      cyc(we, a, d, ev);
      chkIrq("R8 random irq");
      rd("R5 random read", 5'($urandom() % 20));
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule